// File: doc/BRIEF.md
# Slave FIFO Write Sequencer

This block is the master side of a synchronous FIFO write port. It takes packets from an internal valid/ready stream, where each word carries an end-of-packet flag and the target endpoint number. It turns them into the strobe pattern a slave FIFO expects. For each packet it first drives the endpoint number, waits a fixed setup interval, raises chip-select, and then writes one word per clock while the source keeps supplying words. All outputs come from registers, so every accepted word appears on the FIFO pins exactly one clock after its handshake.

The slave commits a packet automatically once it holds a configured number of words (the auto-length). The sequencer keeps its own count of words modulo that length. A packet whose final word fills an auto segment exactly gets no manual commit. Any other packet gets a commit strobe. That strobe normally rides on the same clock as the final word. When the final word is the only word of a new segment directly after an automatic commit, the strobe is moved one clock later, so the slave sees a cycle between its automatic commit and the manual one. The sequencer stops writing while the slave reports full, and holds the endpoint steady around every commit.

Top module: `sfifo_wr_seq`

## Requirements
- R1: While and after reset, and until a packet arrives, `fifo_sel`, `fifo_we`, `fifo_commit` and `src_ready` are all low.
- R2: `fifo_ep` takes the `src_ep` value of a packet. It changes only while `fifo_sel` is low, and `fifo_sel` rises no earlier than SETUP_CYC clocks after the last change of `fifo_ep`.
- R3: `fifo_sel` is high in every cycle where `fifo_we` or `fifo_commit` is high.
- R4: Every word accepted on the source handshake appears on `fifo_dq` with `fifo_we` high in the following cycle, in order. Words accepted on consecutive clocks give back-to-back write cycles.
- R5: In any cycle where `fifo_full` is high, `src_ready` is low, and `fifo_we` is low in the next cycle.
- R6: A packet whose word count is not a multiple of AUTO_LEN, and which is not covered by R8, has `fifo_commit` high in the same cycle as the `fifo_we` of its final word.
- R7: A packet whose word count is a whole multiple of AUTO_LEN produces no `fifo_commit`.
- R8: The deferred case is when the final word is the first word of a new auto segment and the word written just before it completed an auto segment. This covers both the same packet and the end of the previous packet. In that case `fifo_commit` is high one cycle after that word's write cycle, with `fifo_we` low.
- R9: `fifo_ep` holds the packet's endpoint during the commit cycle and does not change between the previous cycle and the commit cycle.
- R10: `fifo_we` is low in the cycle after the write cycle of a packet's final word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the slave FIFO |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Source word valid |
| src_ready | output | 1 | Sequencer accepts the source word this cycle |
| src_data | input | DATA_W | Source word |
| src_last | input | 1 | Marks the final word of a packet |
| src_ep | input | ADDR_W | Endpoint number, constant for a whole packet |
| fifo_full | input | 1 | Slave FIFO full flag, active high |
| fifo_ep | output | ADDR_W | Endpoint address to the slave |
| fifo_dq | output | DATA_W | Write data to the slave |
| fifo_sel | output | 1 | Chip-select, active high |
| fifo_we | output | 1 | Write strobe, active high |
| fifo_commit | output | 1 | Packet-end strobe, active high |

## Verification
The bound checker watches the invariants on every clock. These are chip-select covering every strobe, the endpoint changing only while deselected with the setup interval counted before chip-select rises, no write after a full cycle, the endpoint held across a commit, a commit without a write only directly after a write, and no write after the final word. The bench scenarios cover the behaviour that depends on word counts across packets: which packets get no commit, which get it with the final word, and which get it one cycle late. They also check that data order and burst contiguity hold through a full-flag stall. Only a bench that tracks packet lengths can tell these cases apart.

// File: rtl/sfwr_pkg.sv
package sfwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WRITE,
        ST_LATE
    } seq_state_e;

    typedef enum logic [1:0] {
        END_NONE,
        END_WITH_WORD,
        END_DEFERRED
    } end_kind_e;

    typedef struct packed {
        logic sel;
        logic we;
        logic commit;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{sel: 1'b0, we: 1'b0, commit: 1'b0};

    // Decide how the final word of a packet is committed.
    function automatic end_kind_e pick_end(input logic on_boundary,
                                           input logic seg_start,
                                           input logic after_auto);
        if (on_boundary)
            return END_NONE;
        else if (seg_start && after_auto)
            return END_DEFERRED;
        else
            return END_WITH_WORD;
    endfunction

endpackage

// File: rtl/sfwr_setup_timer.sv
module sfwr_setup_timer #(
    parameter int SETUP_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int TW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

    logic [TW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= '0;
        else if (load)
            remain_q <= TW'(SETUP_CYC - 1);
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/sfwr_auto_tracker.sv
module sfwr_auto_tracker #(
    parameter int AUTO_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic last,
    output logic on_boundary,
    output logic seg_start,
    output logic after_auto
);
    localparam int CW = $clog2(AUTO_LEN);

    logic [CW-1:0] pos_q;
    logic          auto_q;

    assign on_boundary = (pos_q == CW'(AUTO_LEN - 1));
    assign seg_start   = (pos_q == '0);
    assign after_auto  = auto_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            auto_q <= 1'b0;
        end else if (fire) begin
            // every packet end leaves the slave with an empty segment
            if (last || on_boundary)
                pos_q <= '0;
            else
                pos_q <= pos_q + 1'b1;
            auto_q <= on_boundary;
        end
    end

endmodule

// File: rtl/sfwr_out_stage.sv
module sfwr_out_stage
    import sfwr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_word,
    input  logic [DATA_W-1:0] word_in,
    input  logic              ld_ep,
    input  logic [ADDR_W-1:0] ep_in,
    input  strobe_t           strb_in,
    output logic [DATA_W-1:0] word_q,
    output logic [ADDR_W-1:0] ep_q,
    output strobe_t           strb_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            ep_q   <= '0;
            strb_q <= STROBE_OFF;
        end else begin
            strb_q <= strb_in;
            if (ld_word) word_q <= word_in;
            if (ld_ep)   ep_q   <= ep_in;
        end
    end

endmodule

// File: rtl/sfifo_wr_seq.sv
module sfifo_wr_seq
    import sfwr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 2,
    parameter int AUTO_LEN  = 4,
    parameter int SETUP_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_last,
    input  logic [ADDR_W-1:0] src_ep,
    input  logic              fifo_full,
    output logic [ADDR_W-1:0] fifo_ep,
    output logic [DATA_W-1:0] fifo_dq,
    output logic              fifo_sel,
    output logic              fifo_we,
    output logic              fifo_commit
);
    seq_state_e state_q, state_d;
    end_kind_e  end_kind;
    strobe_t    strb_d, strb_q;
    logic       fire, ld_ep, setup_done;
    logic       on_boundary, seg_start, after_auto;

    assign src_ready = (state_q == ST_WRITE) && !fifo_full;
    assign fire      = src_ready && src_valid;
    assign ld_ep     = (state_q == ST_IDLE) && src_valid;

    sfwr_setup_timer #(.SETUP_CYC(SETUP_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (ld_ep),
        .expired (setup_done)
    );

    sfwr_auto_tracker #(.AUTO_LEN(AUTO_LEN)) u_track (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .last        (src_last),
        .on_boundary (on_boundary),
        .seg_start   (seg_start),
        .after_auto  (after_auto)
    );

    assign end_kind = pick_end(on_boundary, seg_start, after_auto);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (src_valid) state_d = ST_SETUP;
            ST_SETUP: if (setup_done) state_d = ST_WRITE;
            ST_WRITE: if (fire && src_last)
                          state_d = (end_kind == END_DEFERRED) ? ST_LATE : ST_IDLE;
            ST_LATE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        strb_d.we     = fire;
        strb_d.commit = (fire && src_last && end_kind == END_WITH_WORD)
                      || (state_q == ST_LATE);
        strb_d.sel    = (state_d == ST_WRITE) || strb_d.we || strb_d.commit;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    sfwr_out_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .ld_word (fire),
        .word_in (src_data),
        .ld_ep   (ld_ep),
        .ep_in   (src_ep),
        .strb_in (strb_d),
        .word_q  (fifo_dq),
        .ep_q    (fifo_ep),
        .strb_q  (strb_q)
    );

    assign fifo_sel    = strb_q.sel;
    assign fifo_we     = strb_q.we;
    assign fifo_commit = strb_q.commit;

endmodule

// File: rtl/sfifo_wr_seq_chk.sv
module sfifo_wr_seq_chk #(
    parameter int ADDR_W    = 2,
    parameter int SETUP_CYC = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              src_ready,
    input logic              fifo_full,
    input logic [ADDR_W-1:0] fifo_ep,
    input logic              fifo_sel,
    input logic              fifo_we,
    input logic              fifo_commit
);
    localparam int HW = $clog2(SETUP_CYC + 2) + 1;

    logic [ADDR_W-1:0] prev_ep;
    logic [HW-1:0]     held_q;
    logic              ep_chg;
    logic [HW-1:0]     held;

    assign ep_chg = (fifo_ep != prev_ep);
    assign held   = ep_chg ? '0 : held_q;

    always_ff @(posedge clk) begin
        prev_ep <= fifo_ep;
        if (rst)
            held_q <= HW'(SETUP_CYC);
        else if (ep_chg)
            held_q <= HW'(1);
        else if (held_q < HW'(SETUP_CYC))
            held_q <= held_q + 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!fifo_sel && !fifo_we && !fifo_commit));

    // R2
    ep_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fifo_ep) |-> !fifo_sel);

    // R2
    ep_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fifo_sel) |-> (held >= HW'(SETUP_CYC)));

    // R3
    sel_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_we || fifo_commit) |-> fifo_sel);

    // R5
    full_ready_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !src_ready);

    // R5
    full_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_full |=> !fifo_we);

    // R8
    late_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_commit && !fifo_we) |-> $past(fifo_we));

    // R9
    commit_ep_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_commit |-> $stable(fifo_ep));

    // R10
    final_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_we && fifo_commit) |=> !fifo_we);

endmodule

bind sfifo_wr_seq sfifo_wr_seq_chk #(.ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .src_ready   (src_ready),
    .fifo_full   (fifo_full),
    .fifo_ep     (fifo_ep),
    .fifo_sel    (fifo_sel),
    .fifo_we     (fifo_we),
    .fifo_commit (fifo_commit)
);

// File: tb/sfifo_wr_seq_bench.sv
`timescale 1ns/1ps
module sfifo_wr_seq_bench;
    localparam int DW = 16;
    localparam int AW = 2;
    localparam int AL = 4;
    localparam int SC = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          src_valid = 1'b0;
    logic          src_ready;
    logic [DW-1:0] src_data = '0;
    logic          src_last = 1'b0;
    logic [AW-1:0] src_ep = '0;
    logic          fifo_full = 1'b0;
    logic [AW-1:0] fifo_ep;
    logic [DW-1:0] fifo_dq;
    logic          fifo_sel, fifo_we, fifo_commit;

    always #2.5 clk = ~clk;

    sfifo_wr_seq #(.DATA_W(DW), .ADDR_W(AW), .AUTO_LEN(AL), .SETUP_CYC(SC)) u_sfifo_wr_seq (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_ready(src_ready),
        .src_data(src_data), .src_last(src_last), .src_ep(src_ep),
        .fifo_full(fifo_full), .fifo_ep(fifo_ep), .fifo_dq(fifo_dq),
        .fifo_sel(fifo_sel), .fifo_we(fifo_we), .fifo_commit(fifo_commit)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // observation log, filled at falling edges
    int w_data [256];
    int w_ep   [256];
    int w_cyc  [256];
    int w_com  [256];
    int nw = 0;
    int c_cyc [64];
    int c_we  [64];
    int c_ep  [64];
    int nc = 0;
    int cyc = 0;
    int prev_ep = 0;
    int prev_sel = 0;
    int ep_chg_cyc = -100;
    int bad_setup = 0;
    int ep_move_sel = 0;
    int we_nosel = 0;
    int prev_full = 0;
    int stall_we = 0;
    int ready_full = 0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc = cyc + 1;
            if (int'(fifo_ep) != prev_ep) begin
                ep_chg_cyc = cyc;
                if (fifo_sel) ep_move_sel = ep_move_sel + 1;
            end
            if (fifo_sel && !prev_sel && (cyc - ep_chg_cyc) < SC)
                bad_setup = bad_setup + 1;
            if ((fifo_we || fifo_commit) && !fifo_sel) we_nosel = we_nosel + 1;
            if (prev_full != 0 && fifo_we) stall_we = stall_we + 1;
            if (fifo_full && src_ready) ready_full = ready_full + 1;
            if (fifo_we && nw < 256) begin
                w_data[nw] = int'(fifo_dq);
                w_ep[nw]   = int'(fifo_ep);
                w_cyc[nw]  = cyc;
                w_com[nw]  = int'(fifo_commit);
                nw = nw + 1;
            end
            if (fifo_commit && nc < 64) begin
                c_cyc[nc] = cyc;
                c_we[nc]  = int'(fifo_we);
                c_ep[nc]  = int'(fifo_ep);
                nc = nc + 1;
            end
            prev_ep   = int'(fifo_ep);
            prev_sel  = int'(fifo_sel);
            prev_full = int'(fifo_full);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_pkt(input int ep, input int n, input int base);
        @(posedge clk); #1;
        src_valid = 1'b1;
        src_ep    = AW'(ep);
        for (int i = 0; i < n; i++) begin
            src_data = DW'(base + i);
            src_last = (i == n - 1);
            forever begin
                @(negedge clk);
                if (src_ready) break;
            end
            @(posedge clk); #1;
        end
        src_valid = 1'b0;
        src_last  = 1'b0;
    endtask

    task automatic drain();
        repeat (8) @(posedge clk);
    endtask

    // kind: 0 = no commit, 1 = commit with final word, 2 = commit one cycle late
    task automatic judge(input string req, input int s, input int sc, input int ep,
                         input int n, input int base, input int kind, input bit burst);
        chk(nw - s == n, "R4", {req, " write count"}, nw - s, n);
        chk(nw - s == n, "R10", {req, " no extra write after final word"}, nw - s, n);
        for (int i = 0; i < n && s + i < nw; i++) begin
            chk(w_data[s+i] == base + i, "R4", {req, " data order"}, w_data[s+i], base + i);
            chk(w_ep[s+i] == ep, "R2", {req, " endpoint on write"}, w_ep[s+i], ep);
            if (burst && i > 0)
                chk(w_cyc[s+i] == w_cyc[s] + i, "R4", {req, " back-to-back"},
                    w_cyc[s+i] - w_cyc[s], i);
        end
        if (kind == 0) begin
            chk(nc == sc, "R7", {req, " no commit"}, nc - sc, 0);
        end else begin
            chk(nc - sc == 1, kind == 1 ? "R6" : "R8", {req, " one commit"}, nc - sc, 1);
            if (nc - sc == 1 && nw > s) begin
                if (kind == 1) begin
                    chk(c_cyc[sc] == w_cyc[nw-1], "R6", {req, " commit with final word"},
                        c_cyc[sc], w_cyc[nw-1]);
                    chk(w_com[nw-1] == 1, "R6", {req, " commit flag on final write"},
                        w_com[nw-1], 1);
                end else begin
                    chk(c_cyc[sc] == w_cyc[nw-1] + 1, "R8", {req, " commit one cycle late"},
                        c_cyc[sc], w_cyc[nw-1] + 1);
                    chk(c_we[sc] == 0, "R8", {req, " no write in late commit"}, c_we[sc], 0);
                end
                chk(c_ep[sc] == ep, "R9", {req, " endpoint at commit"}, c_ep[sc], ep);
            end
        end
    endtask

    task automatic run_pkt(input string req, input int ep, input int n,
                           input int base, input int kind);
        int s, sc;
        s = nw; sc = nc;
        send_pkt(ep, n, base);
        drain();
        judge(req, s, sc, ep, n, base, kind, 1'b1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!fifo_sel && !fifo_we && !fifo_commit, "R1", "strobes in reset",
            int'({fifo_sel, fifo_we, fifo_commit}), 0);
        @(posedge clk); #1 rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!fifo_sel && !fifo_we && !fifo_commit && !src_ready, "R1", "idle after reset",
            int'({fifo_sel, fifo_we, fifo_commit, src_ready}), 0);
    endtask

    task automatic t_single();      run_pkt("R6 single word",      1, 1, 16'h0100, 1); endtask
    task automatic t_short_burst(); run_pkt("R6 three-word burst", 2, 3, 16'h0200, 1); endtask
    task automatic t_exact_auto();  run_pkt("R7 exact auto length", 0, 4, 16'h0300, 0); endtask
    task automatic t_one_after();   run_pkt("R8 one word after auto", 0, 1, 16'h0400, 2); endtask
    task automatic t_auto_plus1();  run_pkt("R8 auto plus one",    3, 5, 16'h0500, 2); endtask
    task automatic t_auto_plus2();  run_pkt("R6 auto plus two",    1, 6, 16'h0600, 1); endtask

    task automatic t_full_stall();
        int s, sc;
        s = nw; sc = nc;
        fork
            send_pkt(3, 6, 16'h0700);
            begin
                while (nw - s < 2) @(posedge clk);
                #1 fifo_full = 1'b1;
                repeat (4) @(posedge clk);
                #1 fifo_full = 1'b0;
            end
        join
        drain();
        judge("R5 full stall", s, sc, 3, 6, 16'h0700, 1, 1'b0);
        chk(stall_we == 0, "R5", "write after full cycle", stall_we, 0);
        chk(ready_full == 0, "R5", "ready while full", ready_full, 0);
        chk(w_cyc[nw-1] - w_cyc[s] > 5, "R5", "burst stretched by stall",
            w_cyc[nw-1] - w_cyc[s], 6);
    endtask

    initial begin
        t_reset();
        t_single();
        t_short_burst();
        t_exact_auto();
        t_one_after();
        t_auto_plus1();
        t_auto_plus2();
        t_full_stall();
        chk(bad_setup == 0, "R2", "setup interval before select", bad_setup, 0);
        chk(ep_move_sel == 0, "R2", "endpoint moved while selected", ep_move_sel, 0);
        chk(we_nosel == 0, "R3", "strobe without select", we_nosel, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule